// File: doc/BRIEF.md
# Keypad Decode and Tone Control

This block watches a four-by-four telephone keypad and decides which tones a dual-tone synthesizer should play. Each of the eight keypad lines is active low. A pressed key pulls exactly one row line and one column line low. The block sorts every line pattern into one of three cases: a valid tone pair, a single tone, or no tone. It then drives a low-group tone select and a high-group tone select, each with its own enable. It also drives a mute output and a run enable that starts the oscillator and the synthesizer.

Two control inputs shape the result. A tone-disable input, when low, forces the tone path inactive. A single-tone-allow input, when high, permits the single-tone cases that arise when several rows or several columns close at once. When it is low, those cases give no tone. The mute output follows key activity and ignores both control inputs. Every input passes through a two-flop synchronizer, and every output is registered.

Top module: `ktc_keypad_ctrl`

## Requirements
- R1: Outputs change on the third rising clock edge after an input change (two synchronizer stages plus one output register). After two edges they still show the old value.
- R2: With exactly one row and exactly one column low, both enables are high. low_idx is the row number and high_idx is the column number, where line bit k gives index k (bit 0 gives index 0).
- R3: With two or more rows low, exactly one column low and single_ok high, only the high-group tone is enabled, and high_idx is that column's index.
- R4: With exactly one row low, two or more columns low and single_ok high, only the low-group tone is enabled, and low_idx is that row's index.
- R5: With two or more rows and two or more columns low, no tone is enabled, whatever the value of single_ok.
- R6: With single_ok low, any pattern from R3 or R4 gives no tone.
- R7: mute is high exactly when at least one row and at least one column are low, independent of single_ok and tone_dis_n.
- R8: With tone_dis_n low, both enables and run_en are low.
- R9: run_en is high exactly when at least one tone enable is high. Column-only or row-only activity keeps it low.
- R10: A group whose enable is low drives an index of 0.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | 4 | Keypad row lines, active low |
| col_n | input | 4 | Keypad column lines, active low |
| tone_dis_n | input | 1 | Low forces the tone path inactive |
| single_ok | input | 1 | High allows single-tone results |
| low_en | output | 1 | Low-group tone enable |
| low_idx | output | 2 | Low-group row index |
| high_en | output | 1 | High-group tone enable |
| high_idx | output | 2 | High-group column index |
| mute | output | 1 | Key activity indicator |
| run_en | output | 1 | Oscillator and synthesizer run enable |

## Verification
The decode has no memory beyond the synchronizer and the output register. A wrong classification therefore shows up on the enables, the indices or run_en on the third edge after the offending pattern is applied. A synchronizer with a missing or extra stage moves every output by one cycle, so the bench samples both the cycle before the new value is due and the cycle it appears. Corner patterns separate the allow and suppress paths: two rows with one column, one row with two columns, crossed multiples, and single-axis activity. Each is applied with the control inputs in both states.

// File: rtl/ktc_pkg.sv
package ktc_pkg;
    localparam int LINES = 4;
    localparam int IDX_W = $clog2(LINES);

    typedef struct packed {
        logic             low_en;
        logic [IDX_W-1:0] low_idx;
        logic             high_en;
        logic [IDX_W-1:0] high_idx;
        logic             mute;
        logic             run_en;
    } ktc_out_t;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_ONE  = 2'd1,
        GRP_MANY = 2'd2
    } grp_cnt_e;
endpackage

// File: rtl/ktc_sync.sv
module ktc_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = din;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/ktc_group_decode.sv
module ktc_group_decode
    import ktc_pkg::*;
(
    input  logic [LINES-1:0] act,
    output grp_cnt_e         cnt,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] total;

    always_comb begin
        total = '0;
        idx   = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            if (act[k]) begin
                total = total + 1'b1;
                idx   = IDX_W'(k);
            end
        end
        if (total == 0)      cnt = GRP_NONE;
        else if (total == 1) cnt = GRP_ONE;
        else                 cnt = GRP_MANY;
    end
endmodule

// File: rtl/ktc_keypad_ctrl.sv
module ktc_keypad_ctrl
    import ktc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] row_n,
    input  logic [LINES-1:0] col_n,
    input  logic             tone_dis_n,
    input  logic             single_ok,
    output logic             low_en,
    output logic [IDX_W-1:0] low_idx,
    output logic             high_en,
    output logic [IDX_W-1:0] high_idx,
    output logic             mute,
    output logic             run_en
);
    localparam int SW = 2 * LINES + 2;
    localparam logic [SW-1:0] SYNC_RST = {{(2 * LINES) {1'b1}}, 1'b1, 1'b0};

    logic [SW-1:0]    sync_out;
    logic [LINES-1:0] row_act, col_act;
    logic             dis_n_s, sok_s;
    grp_cnt_e         row_cnt, col_cnt;
    logic [IDX_W-1:0] row_idx, col_idx;
    ktc_out_t         out_d, out_q;

    ktc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({row_n, col_n, tone_dis_n, single_ok}),
        .dout  (sync_out)
    );

    assign row_act = ~sync_out[SW-1 -: LINES];
    assign col_act = ~sync_out[LINES+1 -: LINES];
    assign dis_n_s = sync_out[1];
    assign sok_s   = sync_out[0];

    ktc_group_decode u_row (.act(row_act), .cnt(row_cnt), .idx(row_idx));
    ktc_group_decode u_col (.act(col_act), .cnt(col_cnt), .idx(col_idx));

    always_comb begin
        out_d = '0;
        out_d.mute = (row_cnt != GRP_NONE) && (col_cnt != GRP_NONE);
        if (dis_n_s) begin
            if (row_cnt == GRP_ONE && col_cnt == GRP_ONE) begin
                out_d.low_en  = 1'b1;
                out_d.high_en = 1'b1;
            end else if (sok_s && row_cnt == GRP_MANY && col_cnt == GRP_ONE) begin
                out_d.high_en = 1'b1;
            end else if (sok_s && row_cnt == GRP_ONE && col_cnt == GRP_MANY) begin
                out_d.low_en = 1'b1;
            end
        end
        if (out_d.low_en)  out_d.low_idx  = row_idx;
        if (out_d.high_en) out_d.high_idx = col_idx;
        out_d.run_en = out_d.low_en | out_d.high_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign low_en   = out_q.low_en;
    assign low_idx  = out_q.low_idx;
    assign high_en  = out_q.high_en;
    assign high_idx = out_q.high_idx;
    assign mute     = out_q.mute;
    assign run_en   = out_q.run_en;

    // R8
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n_s |=> (!low_en && !high_en && !run_en));

    // R9
    run_follows_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en == (low_en || high_en));

    // R10
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_en |-> low_idx == '0) and (!high_en |-> high_idx == '0));

    // R6
    single_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sok_s |=> (low_en == high_en));

    // R7
    tone_implies_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_en || high_en) |-> mute);
endmodule

// File: tb/test_ktc_keypad_ctrl.sv
module test_ktc_keypad_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] row_n = 4'hF;
    logic [3:0] col_n = 4'hF;
    logic       tone_dis_n = 1'b1;
    logic       single_ok = 1'b0;
    logic       low_en, high_en, mute, run_en;
    logic [1:0] low_idx, high_idx;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    ktc_keypad_ctrl i_ktc_keypad_ctrl (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
        .tone_dis_n(tone_dis_n), .single_ok(single_ok),
        .low_en(low_en), .low_idx(low_idx), .high_en(high_en),
        .high_idx(high_idx), .mute(mute), .run_en(run_en)
    );

    // {row_n, col_n, dis_n, sok, low_en, low_idx, high_en, high_idx, mute, run}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {4'b1110, 4'b1110, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1}, // R2
        {4'b0111, 4'b1011, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 2'd2, 1'b1, 1'b1}, // R2
        {4'b1101, 4'b0111, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 2'd3, 1'b1, 1'b1}, // R2
        {4'b1100, 4'b1110, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1}, // R3
        {4'b1100, 4'b1110, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0}, // R6
        {4'b1011, 4'b0011, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, 1'b1}, // R4
        {4'b1011, 4'b0011, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0}, // R6
        {4'b0011, 4'b1100, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0}, // R5
        {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}, // R7
        {4'b1111, 4'b1101, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}, // R9
        {4'b1110, 4'b1111, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}, // R9
        {4'b1110, 4'b1110, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0}  // R8
    };

    task automatic check(string req, logic [7:0] exp_v);
        logic [7:0] act_v;
        act_v = {low_en, low_idx, high_en, high_idx, mute, run_en};
        n_checks++;
        if (act_v !== exp_v) begin
            n_errs++;
            $display("FAIL %s: got %b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic apply(logic [3:0] r, logic [3:0] c, logic d, logic s);
        @(negedge clk);
        row_n = r; col_n = c; tone_dis_n = d; single_ok = s;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 8'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", 8'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:14], VEC[i][13:10], VEC[i][9], VEC[i][8]);
            settle();
            check($sformatf("R2-group vector %0d", i), VEC[i][7:0]);
        end

        // R1 latency: key pair row 2, column 1 from idle
        apply(4'hF, 4'hF, 1'b1, 1'b1);
        settle();
        apply(4'b1011, 4'b1101, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 two edges", 8'b0);
        @(posedge clk);
        @(negedge clk);
        check("R1 third edge", {1'b1, 2'd2, 1'b1, 2'd1, 1'b1, 1'b1});

        // R7 mute ignores disable with crossed multiples
        apply(4'b0000, 4'b0000, 1'b0, 1'b0);
        settle();
        check("R7 crossed disabled", 8'b00000010);

        // R10 index returns to 0 after a tone
        apply(4'b0111, 4'b0111, 1'b1, 1'b1);
        settle();
        check("R2 row3 col3", {1'b1, 2'd3, 1'b1, 2'd3, 1'b1, 1'b1});
        apply(4'b0111, 4'b0011, 1'b1, 1'b1);
        settle();
        check("R10 high idx cleared", {1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1});

        // R11 reset mid-tone
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset mid-tone", 8'b0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule